// File: doc/BRIEF.md
# Field-Synchronized Capture Address Register Bank

This block holds the memory addresses a video-capture path uses to place incoming pixel data. Software writes a small set of registers over a simple single-cycle register bus. Writes to the frame base addresses do not take effect at once. Each such write goes into a shadow copy, and the copies are moved into the live registers together when the capture logic reports the first pixel data of a new field. Until that move happens, a sticky flag shows that an update is still outstanding, so software can tell when its new addresses are in use.

The block also works out the start address of the U chroma plane. It adds a per-field offset register to the live base of the current field: the even offset with base slot 0, and the odd offset with base slot 1. It also holds a 16-bit end-of-line pixel position, which the capture timing uses when line boundaries come from external sync inputs. The field-start strobe and the field parity come from surrounding logic as plain inputs.

Top module: `capbase_regbank`

## Requirements
- R1: After reset, every register reads zero, every live base is zero, and `upd_pending` is low.
- R2: A write to a base register (word addresses 4 to 4+NUM_BASES-1) changes neither `base_live` nor the value read back from that address. A read always returns the live value.
- R3: Any base-register write sets the pending flag on the next edge. The flag is visible on `upd_pending` and as bit 16 of the status register at word address 0.
- R4: A `field_commit` pulse while the flag is set copies every pending base into its live register on the same edge, and the flag clears.
- R5: If a base write and `field_commit` occur in the same cycle, the commit uses the previously pending values. The newly written value stays pending and the flag stays set.
- R6: A `field_commit` pulse while the flag is clear leaves every live base unchanged and the flag clear.
- R7: Base registers hold 16-byte-aligned addresses: written bits [3:0] are discarded and always read as zero.
- R8: The even U offset (address 2) and the odd U offset (address 3) are 32-byte aligned: written bits [4:0] are discarded and read as zero.
- R9: With `field_odd` = 0, `vid_base` is live base slot 0 and `u_start` is that value plus the even U offset. With `field_odd` = 1, base slot 1 and the odd offset are used. The sum wraps modulo 2^32.
- R10: The line-end register at address 1 stores bits [15:0] of the write data, drives `line_end`, and reads with bits [31:16] as zero.
- R11: Writes to the status address 0 have no effect, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Word address for read and write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data at `reg_addr` |
| field_commit | input | 1 | One-cycle pulse at the first captured data of a field |
| field_odd | input | 1 | Parity of the field being captured (1 = odd) |
| base_live | output | NUM_BASES*DATA_W (128) | All live base registers, slot 0 in the low bits |
| vid_base | output | DATA_W (32) | Live base for the current field |
| u_start | output | DATA_W (32) | U plane start address for the current field |
| line_end | output | LINE_W (16) | End-of-active-video pixel position |
| upd_pending | output | 1 | Base update not yet committed |

## Verification
The assertions assume that `field_commit` is a single-cycle pulse and that bus writes are single-cycle strobes with stable address and data at the clock edge. Some properties about the live registers also rely on no base write landing in the same cycle as the event they check. The random stimulus drives each operation for exactly one cycle and then returns the strobes to idle. It mixes commits with writes at a fixed rate, and it includes unmapped addresses. Directed cases cover the same-cycle write-and-commit collision and commits with nothing pending.

// File: rtl/capbase_pkg.sv
package capbase_pkg;
   localparam int unsigned REG_STATUS    = 0;
   localparam int unsigned REG_LINE_END  = 1;
   localparam int unsigned REG_UOFF_EVEN = 2;
   localparam int unsigned REG_UOFF_ODD  = 3;
   localparam int unsigned REG_BASE0     = 4;

   typedef enum logic [1:0] {
      FLD_EVEN = 2'd0,
      FLD_ODD  = 2'd1
   } field_slot_e;
endpackage

// File: rtl/capbase_areg.sv
module capbase_areg #(
   parameter int unsigned W     = 32,
   parameter int unsigned ALIGN = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] KEEP = {W{1'b1}} << ALIGN;

   generate
      if (ALIGN >= W) begin : g_bad_align
         $error("capbase_areg: ALIGN must be below W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wdata & KEEP;
   end
endmodule

// File: rtl/capbase_shadow.sv
module capbase_shadow #(
   parameter int unsigned W     = 32,
   parameter int unsigned ALIGN = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic         commit,
   output logic [W-1:0] live,
   output logic [W-1:0] pend
);
   localparam logic [W-1:0] KEEP = {W{1'b1}} << ALIGN;

   generate
      if (ALIGN >= W) begin : g_bad_align
         $error("capbase_shadow: ALIGN must be below W");
      end
   endgenerate

   // commit moves the value held before this edge; a same-edge write lands in pend only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live <= '0;
         pend <= '0;
      end else begin
         if (commit) live <= pend;
         if (wr_en)  pend <= wdata & KEEP;
      end
   end
endmodule

// File: rtl/capbase_addrgen.sv
module capbase_addrgen #(
   parameter int unsigned W = 32
) (
   input  logic         field_odd,
   input  logic [W-1:0] base_even,
   input  logic [W-1:0] base_odd,
   input  logic [W-1:0] off_even,
   input  logic [W-1:0] off_odd,
   output logic [W-1:0] vid_base,
   output logic [W-1:0] u_start
);
   import capbase_pkg::*;

   field_slot_e slot;
   logic [W-1:0] off_sel;

   always_comb begin
      slot     = field_odd ? FLD_ODD : FLD_EVEN;
      vid_base = (slot == FLD_ODD) ? base_odd : base_even;
      off_sel  = (slot == FLD_ODD) ? off_odd  : off_even;
      u_start  = vid_base + off_sel;
   end
endmodule

// File: rtl/capbase_regbank.sv
module capbase_regbank #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned NUM_BASES  = 4,
   parameter int unsigned BASE_ALIGN = 4,
   parameter int unsigned UOFF_ALIGN = 5,
   parameter int unsigned LINE_W     = 16,
   parameter int unsigned FLAG_BIT   = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [DATA_W-1:0]           reg_wdata,
   output logic [DATA_W-1:0]           reg_rdata,
   input  logic                        field_commit,
   input  logic                        field_odd,
   output logic [NUM_BASES*DATA_W-1:0] base_live,
   output logic [DATA_W-1:0]           vid_base,
   output logic [DATA_W-1:0]           u_start,
   output logic [LINE_W-1:0]           line_end,
   output logic                        upd_pending
);
   import capbase_pkg::*;

   localparam int unsigned NUM_REGS = REG_BASE0 + NUM_BASES;

   generate
      if (NUM_BASES < 2) begin : g_bad_bases
         $error("capbase_regbank: need at least an even and an odd base");
      end
      if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
         $error("capbase_regbank: ADDR_W too small for the register map");
      end
      if (LINE_W > DATA_W || FLAG_BIT >= DATA_W) begin : g_bad_fields
         $error("capbase_regbank: field does not fit the data width");
      end
   endgenerate

   logic [NUM_BASES-1:0] base_wr;
   logic                 any_base_wr;
   logic                 flag_q;
   logic                 commit_en;
   logic [DATA_W-1:0]    live_arr [NUM_BASES];
   logic [DATA_W-1:0]    pend_arr [NUM_BASES];
   logic [DATA_W-1:0]    uoff_even, uoff_odd;
   logic                 wr_line, wr_ueven, wr_uodd;

   assign wr_line   = reg_wr && (reg_addr == ADDR_W'(REG_LINE_END));
   assign wr_ueven  = reg_wr && (reg_addr == ADDR_W'(REG_UOFF_EVEN));
   assign wr_uodd   = reg_wr && (reg_addr == ADDR_W'(REG_UOFF_ODD));
   assign any_base_wr = |base_wr;
   assign commit_en = field_commit && flag_q;

   // sticky flag: a write wins over a commit in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q <= 1'b0;
      else if (any_base_wr)  flag_q <= 1'b1;
      else if (field_commit) flag_q <= 1'b0;
   end
   assign upd_pending = flag_q;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_BASES; gi++) begin : g_base
         assign base_wr[gi] = reg_wr && (reg_addr == ADDR_W'(REG_BASE0 + gi));
         capbase_shadow #(
            .W     (DATA_W),
            .ALIGN (BASE_ALIGN)
         ) u_shadow (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (base_wr[gi]),
            .wdata  (reg_wdata),
            .commit (commit_en),
            .live   (live_arr[gi]),
            .pend   (pend_arr[gi])
         );
         assign base_live[gi*DATA_W +: DATA_W] = live_arr[gi];
      end
   endgenerate

   capbase_areg #(.W(DATA_W), .ALIGN(UOFF_ALIGN)) u_uoff_even (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ueven), .wdata(reg_wdata), .q(uoff_even)
   );
   capbase_areg #(.W(DATA_W), .ALIGN(UOFF_ALIGN)) u_uoff_odd (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_uodd), .wdata(reg_wdata), .q(uoff_odd)
   );
   capbase_areg #(.W(LINE_W), .ALIGN(0)) u_line_end (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_line), .wdata(reg_wdata[LINE_W-1:0]), .q(line_end)
   );

   capbase_addrgen #(.W(DATA_W)) u_addrgen (
      .field_odd (field_odd),
      .base_even (live_arr[0]),
      .base_odd  (live_arr[1]),
      .off_even  (uoff_even),
      .off_odd   (uoff_odd),
      .vid_base  (vid_base),
      .u_start   (u_start)
   );

   // pending copies are never visible on the bus; reads return live state
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(REG_STATUS))    reg_rdata[FLAG_BIT] = flag_q;
      if (reg_addr == ADDR_W'(REG_LINE_END))  reg_rdata = DATA_W'(line_end);
      if (reg_addr == ADDR_W'(REG_UOFF_EVEN)) reg_rdata = uoff_even;
      if (reg_addr == ADDR_W'(REG_UOFF_ODD))  reg_rdata = uoff_odd;
      for (int i = 0; i < NUM_BASES; i++) begin
         if (reg_addr == ADDR_W'(REG_BASE0 + i)) reg_rdata = live_arr[i];
      end
   end

   logic unused_pend;
   always_comb begin
      unused_pend = 1'b0;
      for (int i = 0; i < NUM_BASES; i++) unused_pend = unused_pend ^ (^pend_arr[i]);
   end
endmodule

// File: rtl/capbase_regbank_chk.sv
module capbase_regbank_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned NUM_BASES  = 4,
   parameter int unsigned BASE_ALIGN = 4,
   parameter int unsigned UOFF_ALIGN = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        reg_wr,
   input logic [ADDR_W-1:0]           reg_addr,
   input logic                        field_commit,
   input logic [NUM_BASES*DATA_W-1:0] base_live,
   input logic [DATA_W-1:0]           vid_base,
   input logic [DATA_W-1:0]           u_start,
   input logic                        upd_pending
);
   localparam int unsigned FIRST_BASE = 4;
   localparam int unsigned LAST_BASE  = FIRST_BASE + NUM_BASES - 1;

   function automatic logic [NUM_BASES*DATA_W-1:0] low_mask();
      logic [NUM_BASES*DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_BASES; i++)
         m[i*DATA_W +: DATA_W] = ~({DATA_W{1'b1}} << BASE_ALIGN);
      return m;
   endfunction
   localparam logic [NUM_BASES*DATA_W-1:0] LOW_MASK = low_mask();

   logic bwr;
   assign bwr = reg_wr && (32'(reg_addr) >= FIRST_BASE) && (32'(reg_addr) <= LAST_BASE);

   // R3
   set_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bwr |=> upd_pending);

   // R4
   clear_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (field_commit && upd_pending && !bwr) |=> !upd_pending);

   // R2
   write_no_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bwr && !field_commit) |=> $stable(base_live));

   // R6
   idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (field_commit && !upd_pending && !bwr) |=> ($stable(base_live) && !upd_pending));

   // R7
   base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (base_live & LOW_MASK) == '0);

   // R9
   u_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      u_start[UOFF_ALIGN-1:0] == vid_base[UOFF_ALIGN-1:0]);
endmodule

bind capbase_regbank capbase_regbank_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_BASES(NUM_BASES),
   .BASE_ALIGN(BASE_ALIGN), .UOFF_ALIGN(UOFF_ALIGN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .field_commit(field_commit), .base_live(base_live), .vid_base(vid_base),
   .u_start(u_start), .upd_pending(upd_pending)
);

// File: tb/capbase_regbank_bench.sv
module capbase_regbank_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          field_commit = 1'b0;
   logic          field_odd = 1'b0;
   logic [NB*32-1:0] base_live;
   logic [31:0]   vid_base, u_start;
   logic [15:0]   line_end;
   logic          upd_pending;

   int vectors = 0;
   int fails = 0;

   logic [31:0] m_pend [NB];
   logic [31:0] m_live [NB];
   logic        m_flag;
   logic [31:0] m_ueven, m_uodd;
   logic [15:0] m_line;

   always #(CLK_PERIOD/2) clk = ~clk;

   capbase_regbank u_capbase_regbank (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .field_commit(field_commit),
      .field_odd(field_odd), .base_live(base_live), .vid_base(vid_base),
      .u_start(u_start), .line_end(line_end), .upd_pending(upd_pending)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      if (a == 0) return {15'd0, m_flag, 16'd0};
      if (a == 1) return {16'd0, m_line};
      if (a == 2) return m_ueven;
      if (a == 3) return m_uodd;
      if (a >= 4 && a < 4 + NB) return m_live[a-4];
      return 32'd0;
   endfunction

   function automatic string read_tag(input logic [3:0] a);
      if (a == 0) return "R3";
      if (a == 1) return "R10";
      if (a == 2 || a == 3) return "R8";
      if (a >= 4 && a < 4 + NB) return "R2";
      return "R11";
   endfunction

   task automatic model_edge(input logic w, input logic [3:0] a, input logic [31:0] d, input logic c);
      logic base_w;
      base_w = w && a >= 4 && a < 4 + NB;
      if (c && m_flag) begin
         for (int i = 0; i < NB; i++) m_live[i] = m_pend[i];
      end
      if (w && a == 1) m_line = d[15:0];
      if (w && a == 2) m_ueven = d & 32'hFFFF_FFE0;
      if (w && a == 3) m_uodd = d & 32'hFFFF_FFE0;
      if (base_w) m_pend[a-4] = d & 32'hFFFF_FFF0;
      if (base_w) m_flag = 1'b1;
      else if (c) m_flag = 1'b0;
   endtask

   task automatic check_outs();
      logic [31:0] eb;
      eb = field_odd ? m_live[1] : m_live[0];
      check("R9 vid_base", vid_base, eb);
      check("R9 u_start", u_start, eb + (field_odd ? m_uodd : m_ueven));
      check("R4 upd_pending", {31'd0, upd_pending}, {31'd0, m_flag});
      for (int i = 0; i < NB; i++) check("R4 base_live", base_live[i*32 +: 32], m_live[i]);
      check("R10 line_end", {16'd0, line_end}, {16'd0, m_line});
   endtask

   task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic c, input logic o);
      @(negedge clk);
      reg_wr = w; reg_addr = a; reg_wdata = d; field_commit = c; field_odd = o;
      @(posedge clk);
      model_edge(w, a, d, c);
      @(negedge clk);
      reg_wr = 1'b0; field_commit = 1'b0;
      check_outs();
   endtask

   task automatic rd(input logic [3:0] a);
      @(negedge clk);
      reg_wr = 1'b0; field_commit = 1'b0; reg_addr = a;
      #1;
      check(read_tag(a), reg_rdata, exp_read(a));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      for (int i = 0; i < NB; i++) begin m_pend[i] = '0; m_live[i] = '0; end
      m_flag = 1'b0; m_ueven = '0; m_uodd = '0; m_line = '0;
      seed = $urandom(32'h5EED_0042);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 16; a++) rd(4'(a));
      @(negedge clk); check_outs();

      // R2, R3, R7: base write stays pending, low bits dropped
      step(1'b1, 4'd4, 32'h1234_567F, 1'b0, 1'b0);
      rd(4'd4);
      rd(4'd0);
      // R4: commit moves it
      step(1'b0, 4'd0, 32'h0, 1'b1, 1'b0);
      check("R7 aligned", base_live[31:0], 32'h1234_5670);
      // R6: commit with nothing pending
      step(1'b0, 4'd0, 32'h0, 1'b1, 1'b1);
      // R5: write and commit together
      step(1'b1, 4'd5, 32'hAAAA_0001, 1'b0, 1'b1);
      step(1'b1, 4'd5, 32'hBBBB_0002, 1'b1, 1'b1);
      check("R5 odd live old pending", base_live[63:32], 32'hAAAA_0000);
      step(1'b0, 4'd0, 32'h0, 1'b1, 1'b1);
      check("R5 odd live new", base_live[63:32], 32'hBBBB_0000);
      // R8, R9 wrap
      step(1'b1, 4'd3, 32'hFFFF_FFFF, 1'b0, 1'b1);
      rd(4'd3);
      // R10 upper bits dropped
      step(1'b1, 4'd1, 32'hDEAD_BEEF, 1'b0, 1'b0);
      rd(4'd1);
      // R11 status write ignored, unmapped reads
      step(1'b1, 4'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
      rd(4'd0);
      rd(4'd15);

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic w, c, o;
         logic [3:0] a;
         logic [31:0] d;
         w = ($urandom % 4) != 0;
         c = ($urandom % 4) == 0;
         o = 1'($urandom);
         a = 4'($urandom % 10);
         d = $urandom;
         step(w, a, d, c, o);
         rd(4'($urandom % 16));
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule